// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device-side logic of a serial EEPROM that a host reaches over three wires: a chip-select, a serial clock and a serial data input. It also drives one serial data output with an enable. The block samples all three pins with a faster system clock. It detects the rising edges of the serial clock, and it captures the data input on each rising edge. Every frame opens with a start bit and a two-bit opcode, followed by an address field. Write frames then carry a data word. The block decodes a read, a word write and a word erase, plus an extended group that enables programming, disables programming, erases the whole array or writes the whole array.

The storage is a register array inside the block. A parameter selects the organisation: 16-bit words with an 8-bit address, or 8-bit words with a 9-bit address. A counter stands in for the self-timed programming cycle. Programming is locked after reset and stays locked until the host sends an enable frame. While a programming cycle runs, the host can pull chip-select low for a minimum time and raise it again. The output then reports busy (0) or ready (1). A read first sends a zero dummy bit and then streams words with no gap, stepping the address after each word for as long as chip-select stays high.

Top module: `three_wire_eeprom`

## Requirements
- R1: After reset, every word of the array reads as all ones, programming is locked, and the output enable is low.
- R2: A frame begins on the first sampled 1 while chip-select is high, so zeros before it are ignored. The two bits after the start bit are the opcode, shifted in MSB first: 10 is read, 01 is write, 11 is erase and 00 is the extended group.
- R3: A read drives 0 as a dummy bit from the rising serial-clock edge that captures the last address bit. Each following rising edge then drives the next data bit, MSB first, with the output enable high.
- R4: While chip-select stays high, a read goes on to the next address with no dummy bit between words. The address wraps from the top word to word 0.
- R5: While programming is locked, write, erase, erase-all and write-all frames change no word and start no busy cycle.
- R6: In the extended group, the two most significant address bits select the command: 11 enables programming and 00 disables it. The remaining address bits are clocked in but ignored.
- R7: A write frame stores the data word that follows the address, MSB first, at that address.
- R8: Erase sets the addressed word to all ones. Extended code 10 (erase-all) sets every word to all ones.
- R9: Extended code 01 (write-all) stores the following data word into every word of the array.
- R10: Each accepted programming command starts a busy period of PROG_CYCLES system clocks. After chip-select has been low for at least CS_LOW_MIN system clocks and then returns high, the output is enabled and shows 0 while busy and 1 once ready. A shorter low pulse shows nothing.
- R11: A start bit that arrives while the block is busy is ignored, so the whole frame has no effect.
- R12: Chip-select low aborts any partial frame and forces the output enable and output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Chip-select, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_in | input | 1 | Serial data from the host |
| ser_out | output | 1 | Serial data or ready/busy status to the host |
| ser_out_en | output | 1 | Output enable for ser_out |

## Verification
A fault in the frame decoder shows up on the output within one frame. The dummy bit or the first data bit arrives on the wrong serial edge, or the read-back word differs from the word that was written. A lock flag or busy counter in the wrong state shows up only in a later frame: the word that should be unchanged has changed, or the status pulse reports ready or busy at the wrong time. The bench therefore follows every programming frame with a read-back and a status poll. Only these show the hidden state.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD
    } ctrl_state_e;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_WORD,
        PK_ERASE,
        PK_FILL,
        PK_WIPE
    } prog_kind_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_WRITE,
        CMD_ERASE,
        CMD_UNLOCK,
        CMD_LOCK,
        CMD_WIPE,
        CMD_FILL
    } cmd_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_EXT   = 2'b00;

    function automatic cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] sel);
        cmd_e c;
        case (opc)
            OPC_READ:  c = CMD_READ;
            OPC_WRITE: c = CMD_WRITE;
            OPC_ERASE: c = CMD_ERASE;
            default: begin
                case (sel)
                    2'b11:   c = CMD_UNLOCK;
                    2'b10:   c = CMD_WIPE;
                    2'b01:   c = CMD_FILL;
                    default: c = CMD_LOCK;
                endcase
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_pin,
    input  logic sk_pin,
    input  logic di_pin,
    output logic cs_s,
    output logic cs_rise,
    output logic sk_rise,
    output logic di_s
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] pins;
    logic [NPINS-1:0] synced;
    logic             sk_prev;
    logic             cs_prev;

    assign pins = {di_pin, sk_pin, cs_pin};

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], pins[p]};
            end
        end
        assign synced[p] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_prev <= 1'b0;
            cs_prev <= 1'b0;
        end else begin
            sk_prev <= synced[1];
            cs_prev <= synced[0];
        end
    end

    assign cs_s    = synced[0];
    assign di_s    = synced[2];
    assign sk_rise = synced[1] & ~sk_prev;
    assign cs_rise = synced[0] & ~cs_prev;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(PROG_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start); // R11
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R10

endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  prog_kind_e        kind,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (we) begin
            case (kind)
                PK_WORD:  mem[waddr] <= wdata;
                PK_ERASE: mem[waddr] <= '1;
                PK_FILL:  for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
                PK_WIPE:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                default:  ;
            endcase
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int CS_LOW_MIN = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              cs_rise,
    input  logic              sk_rise,
    input  logic              di_s,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              prog_start,
    output prog_kind_e        prog_kind,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              ser_out,
    output logic              ser_out_en
);
    localparam int CNT_W = $clog2(DATA_W + ADDR_W) + 1;
    localparam int LC_W  = $clog2(CS_LOW_MIN + 1);

    ctrl_state_e       st;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_sh;
    logic [CNT_W-1:0]  cnt;
    logic              wen_q;
    logic              status_en;
    logic              pend_status;
    logic              do_q;
    logic [LC_W-1:0]   low_cnt;

    logic [ADDR_W-1:0] addr_nx;
    logic [DATA_W-1:0] data_nx;
    cmd_e              cmd_nx;

    always_comb begin
        addr_nx = {addr_q[ADDR_W-2:0], di_s};
        data_nx = {data_q[DATA_W-2:0], di_s};
        cmd_nx  = decode_cmd(opc_q, addr_nx[ADDR_W-1 -: 2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            opc_q       <= '0;
            addr_q      <= '0;
            data_q      <= '0;
            rd_sh       <= '0;
            rd_ptr      <= '0;
            cnt         <= '0;
            wen_q       <= 1'b0;
            status_en   <= 1'b0;
            pend_status <= 1'b0;
            do_q        <= 1'b0;
            low_cnt     <= '0;
            prog_start  <= 1'b0;
            prog_kind   <= PK_NONE;
            prog_addr   <= '0;
            prog_data   <= '0;
        end else begin
            prog_start <= 1'b0;
            if (!cs_s) begin
                st        <= ST_IDLE;
                status_en <= 1'b0;
                do_q      <= 1'b0;
                if (low_cnt != LC_W'(CS_LOW_MIN)) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
                if (cs_rise && pend_status && low_cnt == LC_W'(CS_LOW_MIN)) begin
                    status_en <= 1'b1;
                end
                if (sk_rise) begin
                    case (st)
                        ST_IDLE: begin
                            if (di_s && !busy) begin
                                st          <= ST_OPC;
                                cnt         <= '0;
                                opc_q       <= '0;
                                status_en   <= 1'b0;
                                pend_status <= 1'b0;
                            end
                        end
                        ST_OPC: begin
                            opc_q <= {opc_q[0], di_s};
                            if (cnt == CNT_W'(1)) begin
                                st  <= ST_ADDR;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_ADDR: begin
                            addr_q <= addr_nx;
                            if (cnt == CNT_W'(ADDR_W - 1)) begin
                                cnt <= '0;
                                st  <= ST_HOLD;
                                case (cmd_nx)
                                    CMD_READ: begin
                                        st     <= ST_READ;
                                        rd_ptr <= addr_nx;
                                        do_q   <= 1'b0;
                                    end
                                    CMD_WRITE, CMD_FILL: st <= ST_DATA;
                                    CMD_ERASE, CMD_WIPE: begin
                                        if (wen_q && !busy) begin
                                            prog_start  <= 1'b1;
                                            pend_status <= 1'b1;
                                            prog_kind   <= (cmd_nx == CMD_ERASE) ? PK_ERASE : PK_WIPE;
                                            prog_addr   <= addr_nx;
                                        end
                                    end
                                    CMD_UNLOCK: wen_q <= 1'b1;
                                    default:    wen_q <= 1'b0;
                                endcase
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_DATA: begin
                            data_q <= data_nx;
                            if (cnt == CNT_W'(DATA_W - 1)) begin
                                st <= ST_HOLD;
                                if (wen_q && !busy) begin
                                    prog_start  <= 1'b1;
                                    pend_status <= 1'b1;
                                    prog_kind   <= (opc_q == OPC_WRITE) ? PK_WORD : PK_FILL;
                                    prog_addr   <= addr_q;
                                    prog_data   <= data_nx;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_READ: begin
                            if (cnt == '0) begin
                                do_q   <= rd_data[DATA_W-1];
                                rd_sh  <= {rd_data[DATA_W-2:0], 1'b0};
                                cnt    <= CNT_W'(DATA_W - 1);
                                rd_ptr <= rd_ptr + 1'b1;
                            end else begin
                                do_q  <= rd_sh[DATA_W-1];
                                rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                                cnt   <= cnt - 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        ser_out_en = cs_s & (status_en | (st == ST_READ));
        if (!cs_s)          ser_out = 1'b0;
        else if (status_en) ser_out = ~busy;
        else if (st == ST_READ) ser_out = do_q;
        else                ser_out = 1'b0;
    end

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> (st == ST_IDLE)); // R12
    AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> wen_q); // R5
    AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (rst)
        (cs_s && $rose(st == ST_READ)) |-> (do_q == 1'b0)); // R3
    AST_NO_STATUS_NO_CS: assert property (@(posedge clk) disable iff (rst)
        !cs_s |=> !status_en || cs_s); // R12

endmodule

// File: rtl/three_wire_eeprom.sv
module three_wire_eeprom
    import eep_pkg::*;
#(
    parameter bit WORD16      = 1'b1,
    parameter int PROG_CYCLES = 1000,
    parameter int CS_LOW_MIN  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic ser_clk,
    input  logic ser_in,
    output logic ser_out,
    output logic ser_out_en
);
    localparam int ADDR_W = WORD16 ? 8 : 9;
    localparam int DATA_W = WORD16 ? 16 : 8;

    logic              cs_s, cs_rise, sk_rise, di_s;
    logic              busy, prog_start;
    prog_kind_e        prog_kind;
    logic [ADDR_W-1:0] prog_addr, rd_ptr;
    logic [DATA_W-1:0] prog_data, rd_data;

    eep_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .cs_pin(chip_sel), .sk_pin(ser_clk), .di_pin(ser_in),
        .cs_s(cs_s), .cs_rise(cs_rise), .sk_rise(sk_rise), .di_s(di_s)
    );

    eep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_LOW_MIN(CS_LOW_MIN)) u_ctrl (
        .clk(clk), .rst(rst),
        .cs_s(cs_s), .cs_rise(cs_rise), .sk_rise(sk_rise), .di_s(di_s),
        .busy(busy), .rd_data(rd_data), .rd_ptr(rd_ptr),
        .prog_start(prog_start), .prog_kind(prog_kind),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .ser_out(ser_out), .ser_out_en(ser_out_en)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(prog_start), .busy(busy)
    );

    eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst(rst),
        .we(prog_start), .kind(prog_kind),
        .waddr(prog_addr), .wdata(prog_data),
        .raddr(rd_ptr), .rdata(rd_data)
    );

endmodule

// File: tb/tb_three_wire_eeprom.sv
`timescale 1ns/1ps
module tb_three_wire_eeprom;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_sel = 1'b0, ser_clk = 1'b0, ser_in = 1'b0;
    logic ser_out, ser_out_en;
    int   n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    three_wire_eeprom dut (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .ser_clk(ser_clk),
        .ser_in(ser_in), .ser_out(ser_out), .ser_out_en(ser_out_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic v);
        ser_in = v; tick(4);
        ser_clk = 1'b1; tick(8);
        ser_clk = 1'b0; tick(4);
    endtask

    task automatic sbits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic cs_on();  chip_sel = 1'b1; tick(4); endtask
    task automatic cs_off(); chip_sel = 1'b0; ser_in = 1'b0; tick(4); endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        cs_on(); sbits(3'b101, 3); sbits(a, 8); sbits(d, 16); cs_off();
    endtask

    task automatic do_ext(input logic [1:0] sel, input logic [15:0] d, input bit with_data);
        cs_on(); sbits(3'b100, 3); sbits({sel, 6'b101010}, 8);
        if (with_data) sbits(d, 16);
        cs_off();
    endtask

    task automatic do_erase(input logic [7:0] a);
        cs_on(); sbits(3'b111, 3); sbits(a, 8); cs_off();
    endtask

    // long CS-low pulse then poll status until ready; returns 1 if ready seen
    task automatic wait_ready(output bit seen, output bit first_busy);
        seen = 1'b0;
        chip_sel = 1'b0; tick(20);
        chip_sel = 1'b1; tick(6);
        first_busy = ser_out_en && (ser_out == 1'b0);
        for (int i = 0; i < 3000 && !seen; i++) begin
            tick(1);
            if (ser_out_en && ser_out) seen = 1'b1;
        end
        cs_off();
    endtask

    task automatic read_words(input logic [7:0] a, input int n, input int pre0,
                              output logic [15:0] w0, output logic [15:0] w1, output logic dummy);
        logic [15:0] w;
        cs_on();
        if (pre0 > 0) sbits(32'd0, pre0);
        sbits(3'b110, 3); sbits(a, 8);
        dummy = ser_out_en ? ser_out : 1'bx;
        w0 = '0; w1 = '0;
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                sbit(1'b0);
                w = {w[14:0], ser_out};
            end
            if (k == 0) w0 = w; else w1 = w;
        end
        cs_off();
    endtask

    task automatic t_reset();
        logic [15:0] a, b; logic d;
        chk(ser_out_en == 1'b0, "R1 oe after reset", ser_out_en, 0);
        read_words(8'd0, 1, 0, a, b, d);
        chk(a == 16'hFFFF, "R1 word0 after reset", a, 16'hFFFF);
        read_words(8'd77, 1, 0, a, b, d);
        chk(a == 16'hFFFF, "R1 word77 after reset", a, 16'hFFFF);
    endtask

    task automatic t_locked();
        logic [15:0] a, b; logic d;
        do_write(8'd3, 16'h1234);
        chip_sel = 1'b0; tick(20); chip_sel = 1'b1; tick(6);
        chk(ser_out_en == 1'b0, "R5 no busy cycle when locked", ser_out_en, 0);
        cs_off();
        do_erase(8'd3);
        read_words(8'd3, 1, 0, a, b, d);
        chk(a == 16'hFFFF, "R5 locked write ignored", a, 16'hFFFF);
    endtask

    task automatic t_write_read();
        logic [15:0] a, b; logic d; bit s, fb;
        do_ext(2'b11, 16'h0, 1'b0);
        do_write(8'd3, 16'hA55A);
        wait_ready(s, fb);
        chk(fb, "R10 busy shown as 0", fb, 1);
        chk(s, "R10 ready shown as 1", s, 1);
        read_words(8'd3, 1, 0, a, b, d);
        chk(d === 1'b0, "R3 dummy bit", d, 0);
        chk(a == 16'hA55A, "R7 write stored", a, 16'hA55A);
        read_words(8'd3, 1, 2, a, b, d);
        chk(a == 16'hA55A, "R2 leading zeros ignored", a, 16'hA55A);
    endtask

    task automatic t_short_pulse_and_busy();
        logic [15:0] a, b; logic d; bit s, fb;
        do_write(8'd20, 16'h0F0F);
        chk(ser_out_en == 1'b0, "R10 short pulse shows no status", ser_out_en, 0);
        do_write(8'd21, 16'h7777);
        wait_ready(s, fb);
        chk(s, "R10 ready after write", s, 1);
        read_words(8'd21, 1, 0, a, b, d);
        chk(a == 16'hFFFF, "R11 frame during busy ignored", a, 16'hFFFF);
        read_words(8'd20, 1, 0, a, b, d);
        chk(a == 16'h0F0F, "R7 first write kept", a, 16'h0F0F);
    endtask

    task automatic t_seq_read();
        logic [15:0] a, b; logic d; bit s, fb;
        do_write(8'd10, 16'h1111); wait_ready(s, fb);
        do_write(8'd11, 16'h2222); wait_ready(s, fb);
        read_words(8'd10, 2, 0, a, b, d);
        chk(a == 16'h1111, "R4 seq word 0", a, 16'h1111);
        chk(b == 16'h2222, "R4 seq word 1 no dummy", b, 16'h2222);
        do_write(8'd255, 16'hBEEF); wait_ready(s, fb);
        do_write(8'd0, 16'h0042); wait_ready(s, fb);
        read_words(8'd255, 2, 0, a, b, d);
        chk(a == 16'hBEEF, "R4 top word", a, 16'hBEEF);
        chk(b == 16'h0042, "R4 wrap to word 0", b, 16'h0042);
    endtask

    task automatic t_erase_fill();
        logic [15:0] a, b; logic d; bit s, fb;
        do_erase(8'd3); wait_ready(s, fb);
        read_words(8'd3, 1, 0, a, b, d);
        chk(a == 16'hFFFF, "R8 erase word", a, 16'hFFFF);
        do_ext(2'b01, 16'h5A5A, 1'b1); wait_ready(s, fb);
        read_words(8'd0, 1, 0, a, b, d);
        chk(a == 16'h5A5A, "R9 fill word 0", a, 16'h5A5A);
        read_words(8'd200, 1, 0, a, b, d);
        chk(a == 16'h5A5A, "R9 fill word 200", a, 16'h5A5A);
        do_ext(2'b10, 16'h0, 1'b0); wait_ready(s, fb);
        read_words(8'd200, 1, 0, a, b, d);
        chk(a == 16'hFFFF, "R8 erase-all", a, 16'hFFFF);
    endtask

    task automatic t_lock_again_and_abort();
        logic [15:0] a, b; logic d;
        do_ext(2'b00, 16'h0, 1'b0);
        do_write(8'd5, 16'h1357);
        read_words(8'd5, 1, 0, a, b, d);
        chk(a == 16'hFFFF, "R6 lock blocks write", a, 16'hFFFF);
        do_ext(2'b11, 16'h0, 1'b0);
        cs_on(); sbits(3'b101, 3); sbits(8'd6, 8); sbits(16'h00FF, 10);
        chip_sel = 1'b0; tick(6);
        chk(ser_out_en == 1'b0 && ser_out == 1'b0, "R12 outputs low with cs low", {ser_out_en, ser_out}, 0);
        tick(20);
        read_words(8'd6, 1, 0, a, b, d);
        chk(a == 16'hFFFF, "R12 aborted frame no effect", a, 16'hFFFF);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_locked();
        t_write_read();
        t_short_pulse_and_busy();
        t_seq_read();
        t_erase_fill();
        t_lock_again_and_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule